// File: doc/BRIEF.md
# SDRAM Read Turnaround Command Scheduler

This block is the timing core of a single-data-rate SDRAM controller. It takes one request at a time and turns it into a short, fixed command sequence that begins with a four-beat burst READ. A request in close mode then precharges the row early, while the read burst is still returning, and reopens a row with ACTIVE once the precharge recovery time has passed. A request in turn mode follows the READ with a WRITE, which may go to another bank. In that mode the data mask cuts off the trailing read beats and one idle clock is left so the data bus can float before write data is driven.

The CAS latency (2 or 3 clocks) is chosen per request. The command, bank, address and mask outputs are registered. A write-data output enable marks the single cycle in which the controller should drive write data. A beat tracker reports each read data beat in the cycle it is due on the bus, together with its index in the burst. Commands are encoded on the four active-low strobes as {cs_n, ras_n, cas_n, we_n}. Cycle numbers below count from the cycle in which READ is on the outputs (cycle 0). CL is the latched CAS latency, and TRP is the recovery parameter in clocks (at least 1).

Top module: `sdr_turnaround_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, the outputs show NOP (0111), bank 0, address 0, mask low, write enable low, no read beat, and req_ready high.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both high. READ (0101) appears in the next cycle with the read bank, the read column on the low address bits and address bit 10 low. req_ready stays low until the final command of the sequence.
- R3: In close mode rd_beat_valid is high in cycles CL through CL+3, and rd_beat_num counts 0, 1, 2, 3 across those cycles.
- R4: In close mode PRECHARGE (0010) is issued in cycle 4, which is CL-1 cycles before the last read beat. It goes to the read bank, with address bit 10 equal to the latched all-banks flag and every other address bit low.
- R5: In close mode ACTIVE (0011) is issued exactly TRP cycles after PRECHARGE, to the read bank, with the requested row on the address.
- R6: In close mode the mask stays low throughout. In turn mode the mask is high in cycles CL-1 through CL+1, so only beat 0 is delivered: rd_beat_valid is high in cycle CL alone, with rd_beat_num 0.
- R7: In turn mode WRITE (0100) is issued in cycle CL+2, to the write bank and write column with address bit 10 low. wr_oe is high in that cycle only, and the mask is low there.
- R8: req_ready goes high again in the cycle that carries the final command (ACTIVE or WRITE), so a request presented then is accepted at the following edge.
- R9: Every other cycle of a sequence carries NOP with bank 0 and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Scheduler idle, request will be taken |
| req_close | input | 1 | 1: READ then PRECHARGE and ACTIVE; 0: READ then WRITE |
| req_pre_all | input | 1 | PRECHARGE addresses all banks |
| req_cl3 | input | 1 | CAS latency 3 when high, 2 when low |
| req_rd_bank | input | BA_W | Bank of the READ, PRECHARGE and ACTIVE |
| req_rd_col | input | COL_W | Start column of the READ burst |
| req_wr_bank | input | BA_W | Bank of the WRITE |
| req_wr_col | input | COL_W | Column of the WRITE |
| req_row | input | ROW_W | Row opened by ACTIVE |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| sd_dqm | output | 1 | Data mask |
| wr_oe | output | 1 | Drive write data this cycle |
| rd_beat_valid | output | 1 | A read beat is due on the bus this cycle |
| rd_beat_num | output | BN_W | Index of that beat in the burst |

## Verification
Two functions share a cycle. In close mode the PRECHARGE in cycle 4 coincides with a read beat still returning: beat 2 at CL=2 and beat 1 at CL=3. The bench issues close requests at both latencies and, in that cycle, checks the command, its bank and address, beat-valid and the beat index together. The second coincidence is the mask edge: at CL=2 the mask rises in the cycle right after READ, and the mask window ends one cycle before WRITE and wr_oe. Turn requests at both latencies check that the mask, the enable and the lone delivered beat land on their expected cycles. All of this is swept over banks and the all-banks flag.

// File: rtl/sdr_turn_pkg.sv
package sdr_turn_pkg;
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } sdr_cmd_e;

  localparam int BURST_LEN = 4;
  localparam int BN_W      = $clog2(BURST_LEN);
  localparam int CL_LO     = 2;
  localparam int CL_HI     = 3;
  localparam int AP_BIT    = 10;
endpackage

// File: rtl/sdr_beat_tracker.sv
module sdr_beat_tracker
  import sdr_turn_pkg::*;
#(
  parameter int BURST = BURST_LEN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  logic            issue_full,
  input  logic            issue_cl3,
  output logic            beat_valid,
  output logic [BN_W-1:0] beat_num,
  output logic            future_free
);
  localparam int DW = CL_HI + BURST;

  logic [DW-1:0]   due_q;
  logic [DW-1:0]   pat;
  logic [DW-1:0]   pat_sh;
  logic [BN_W-1:0] num_q;

  always_comb begin
    pat    = issue_full ? DW'({BURST{1'b1}}) : DW'(1);
    pat_sh = issue_cl3 ? (pat << CL_HI) : (pat << CL_LO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      due_q <= '0;
      num_q <= '0;
    end else begin
      due_q <= (due_q >> 1) | (issue ? pat_sh : '0);
      if (issue)
        num_q <= '0;
      else if (due_q[0])
        num_q <= num_q + BN_W'(1);
    end
  end

  assign beat_valid  = due_q[0];
  assign beat_num    = num_q;
  assign future_free = ~|due_q[DW-1:1];

  assert_beat_order_R3: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && $past(beat_valid)) |-> (beat_num == $past(beat_num) + BN_W'(1)));
endmodule

// File: rtl/sdr_trp_timer.sv
module sdr_trp_timer #(
  parameter int TRP = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic act_fire,
  output logic expired
);
  localparam int CW = $clog2(TRP + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= CW'(TRP - 1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)
      since_q <= CW'(TRP);
    else if (load)
      since_q <= '0;
    else if (since_q != CW'(TRP))
      since_q <= since_q + CW'(1);
  end

  assign expired = (cnt_q == '0);

  assert_trp_gap_R5: assert property (@(posedge clk) disable iff (rst)
    act_fire |-> (since_q >= CW'(TRP - 1)));
endmodule

// File: rtl/sdr_turn_seq.sv
module sdr_turn_seq
  import sdr_turn_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int TRP    = 3,
  parameter int BURST  = BURST_LEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_close,
  input  logic              req_pre_all,
  input  logic              req_cl3,
  input  logic [BA_W-1:0]   req_rd_bank,
  input  logic [COL_W-1:0]  req_rd_col,
  input  logic [BA_W-1:0]   req_wr_bank,
  input  logic [COL_W-1:0]  req_wr_col,
  input  logic [ROW_W-1:0]  req_row,
  input  logic              future_free,
  input  logic              trp_expired,
  output sdr_cmd_e          cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              dqm,
  output logic              wr_oe,
  output logic              rd_issue,
  output logic              rd_full,
  output logic              rd_cl3,
  output logic              trp_load,
  output logic              act_fire
);
  localparam int PH_MAX = BURST + TRP + CL_HI + 2;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  logic              busy_q, close_q, all_q, cl3_q, pre_done_q;
  logic [PH_W-1:0]   ph_q, ph_nxt;
  logic [BA_W-1:0]   rb_q, wb_q;
  logic [COL_W-1:0]  wcol_q;
  logic [ROW_W-1:0]  row_q;
  logic [PH_W-1:0]   cl_v, mask_lo, mask_hi, wr_at;
  logic              wr_fire;
  logic [ADDR_W-1:0] pre_addr, rd_addr, wr_addr;

  sdr_cmd_e          cmd_q;
  logic [BA_W-1:0]   ba_q;
  logic [ADDR_W-1:0] addr_q;
  logic              dqm_q, oe_q;

  always_comb begin
    ph_nxt   = (ph_q == PH_W'(PH_MAX)) ? ph_q : ph_q + PH_W'(1);
    cl_v     = cl3_q ? PH_W'(CL_HI) : PH_W'(CL_LO);
    mask_lo  = cl_v - PH_W'(1);
    mask_hi  = cl_v + PH_W'(BURST - 3);
    wr_at    = cl_v + PH_W'(2);
    rd_issue = req_valid && !busy_q;
    trp_load = busy_q && close_q && !pre_done_q && (ph_nxt == PH_W'(BURST));
    act_fire = busy_q && close_q && pre_done_q && trp_expired;
    wr_fire  = busy_q && !close_q && (ph_nxt >= wr_at) && future_free;
    pre_addr = '0;
    pre_addr[AP_BIT] = all_q;
    rd_addr  = ADDR_W'(req_rd_col);
    rd_addr[AP_BIT] = 1'b0;
    wr_addr  = ADDR_W'(wcol_q);
    wr_addr[AP_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      close_q    <= 1'b0;
      all_q      <= 1'b0;
      cl3_q      <= 1'b0;
      pre_done_q <= 1'b0;
      ph_q       <= '0;
      rb_q       <= '0;
      wb_q       <= '0;
      wcol_q     <= '0;
      row_q      <= '0;
      cmd_q      <= CMD_NOP;
      ba_q       <= '0;
      addr_q     <= '0;
      dqm_q      <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      dqm_q  <= 1'b0;
      oe_q   <= 1'b0;
      if (rd_issue) begin
        busy_q     <= 1'b1;
        close_q    <= req_close;
        all_q      <= req_pre_all;
        cl3_q      <= req_cl3;
        pre_done_q <= 1'b0;
        ph_q       <= '0;
        rb_q       <= req_rd_bank;
        wb_q       <= req_wr_bank;
        wcol_q     <= req_wr_col;
        row_q      <= req_row;
        cmd_q      <= CMD_RD;
        ba_q       <= req_rd_bank;
        addr_q     <= rd_addr;
      end else if (busy_q) begin
        ph_q <= ph_nxt;
        if (close_q) begin
          if (trp_load) begin
            cmd_q      <= CMD_PRE;
            ba_q       <= rb_q;
            addr_q     <= pre_addr;
            pre_done_q <= 1'b1;
          end else if (act_fire) begin
            cmd_q  <= CMD_ACT;
            ba_q   <= rb_q;
            addr_q <= ADDR_W'(row_q);
            busy_q <= 1'b0;
          end
        end else begin
          dqm_q <= (ph_nxt >= mask_lo) && (ph_nxt <= mask_hi);
          if (wr_fire) begin
            cmd_q  <= CMD_WR;
            ba_q   <= wb_q;
            addr_q <= wr_addr;
            oe_q   <= 1'b1;
            busy_q <= 1'b0;
          end
        end
      end
    end
  end

  assign req_ready = !busy_q;
  assign cmd       = cmd_q;
  assign ba        = ba_q;
  assign addr      = addr_q;
  assign dqm       = dqm_q;
  assign wr_oe     = oe_q;
  assign rd_full   = req_close;
  assign rd_cl3    = req_cl3;

  assert_dqm_turn_only_R6: assert property (@(posedge clk) disable iff (rst)
    dqm_q |-> (busy_q && !close_q));
endmodule

// File: rtl/sdr_turnaround_sched.sv
module sdr_turnaround_sched
  import sdr_turn_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int TRP    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_close,
  input  logic              req_pre_all,
  input  logic              req_cl3,
  input  logic [BA_W-1:0]   req_rd_bank,
  input  logic [COL_W-1:0]  req_rd_col,
  input  logic [BA_W-1:0]   req_wr_bank,
  input  logic [COL_W-1:0]  req_wr_col,
  input  logic [ROW_W-1:0]  req_row,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              sd_dqm,
  output logic              wr_oe,
  output logic              rd_beat_valid,
  output logic [BN_W-1:0]   rd_beat_num
);
  sdr_cmd_e cmd;
  logic     future_free, trp_expired, rd_issue, rd_full, rd_cl3, trp_load, act_fire;

  sdr_turn_seq #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .TRP(TRP), .BURST(BURST_LEN)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_close(req_close), .req_pre_all(req_pre_all), .req_cl3(req_cl3),
    .req_rd_bank(req_rd_bank), .req_rd_col(req_rd_col),
    .req_wr_bank(req_wr_bank), .req_wr_col(req_wr_col), .req_row(req_row),
    .future_free(future_free), .trp_expired(trp_expired),
    .cmd(cmd), .ba(sd_ba), .addr(sd_addr), .dqm(sd_dqm), .wr_oe(wr_oe),
    .rd_issue(rd_issue), .rd_full(rd_full), .rd_cl3(rd_cl3),
    .trp_load(trp_load), .act_fire(act_fire)
  );

  sdr_beat_tracker #(.BURST(BURST_LEN)) u_beats (
    .clk(clk), .rst(rst),
    .issue(rd_issue), .issue_full(rd_full), .issue_cl3(rd_cl3),
    .beat_valid(rd_beat_valid), .beat_num(rd_beat_num),
    .future_free(future_free)
  );

  sdr_trp_timer #(.TRP(TRP)) u_trp (
    .clk(clk), .rst(rst),
    .load(trp_load), .act_fire(act_fire),
    .expired(trp_expired)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  assert_read_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (cmd == CMD_RD));

  assert_pre_in_burst_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |-> rd_beat_valid);

  assert_oe_bus_free_R7: assert property (@(posedge clk) disable iff (rst)
    wr_oe |-> (!rd_beat_valid && !sd_dqm));
endmodule

// File: tb/test_sdr_turnaround_sched.sv
module test_sdr_turnaround_sched;
  localparam int CLK_P  = 10;
  localparam int BA_W   = 2;
  localparam int ROW_W  = 13;
  localparam int COL_W  = 10;
  localparam int ADDR_W = 13;
  localparam int TRP    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic              req_valid = 1'b0, req_close = 1'b0, req_pre_all = 1'b0, req_cl3 = 1'b0;
  logic [BA_W-1:0]   req_rd_bank = '0, req_wr_bank = '0;
  logic [COL_W-1:0]  req_rd_col = '0, req_wr_col = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic              req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, wr_oe, rd_beat_valid;
  logic [BA_W-1:0]   sd_ba;
  logic [ADDR_W-1:0] sd_addr;
  logic [1:0]        rd_beat_num;

  sdr_turnaround_sched #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .TRP(TRP))
  i_sdr_turnaround_sched (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_close(req_close), .req_pre_all(req_pre_all), .req_cl3(req_cl3),
    .req_rd_bank(req_rd_bank), .req_rd_col(req_rd_col),
    .req_wr_bank(req_wr_bank), .req_wr_col(req_wr_col), .req_row(req_row),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .wr_oe(wr_oe),
    .rd_beat_valid(rd_beat_valid), .rd_beat_num(rd_beat_num)
  );

  int errs = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int cmd_now();
    return int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n});
  endfunction

  task automatic check_idle_outputs(input string req);
    chk(cmd_now() == 7, req, "NOP cmd", cmd_now(), 7);
    chk(sd_ba == 0 && sd_addr == 0, req, "idle bank/addr", int'(sd_addr), 0);
    chk(sd_dqm == 0 && wr_oe == 0, req, "idle mask/oe", int'({sd_dqm, wr_oe}), 0);
    chk(rd_beat_valid == 0, req, "idle beat", int'(rd_beat_valid), 0);
    chk(req_ready == 1, req, "idle ready", int'(req_ready), 1);
  endtask

  task automatic run_one(input bit c3, input bit close, input bit all,
                         input int rb, input int wb, input int rcol, input int wcol, input int row);
    int cl, last, e_cmd, e_ba, e_addr, e_num;
    bit e_dqm, e_oe, e_bv;
    string rq;
    cl   = c3 ? 3 : 2;
    last = close ? 4 + TRP : cl + 2;
    chk(req_ready == 1, "R8", "ready before request", int'(req_ready), 1);
    req_cl3 = c3; req_close = close; req_pre_all = all;
    req_rd_bank = BA_W'(rb); req_wr_bank = BA_W'(wb);
    req_rd_col = COL_W'(rcol); req_wr_col = COL_W'(wcol); req_row = ROW_W'(row);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t <= last; t++) begin
      if (t > 0) @(negedge clk);
      e_cmd = 7; e_ba = 0; e_addr = 0; rq = "R9";
      if (t == 0) begin
        e_cmd = 5; e_ba = rb; e_addr = rcol; rq = "R2";
      end else if (close && t == 4) begin
        e_cmd = 2; e_ba = rb; e_addr = all ? 1024 : 0; rq = "R4";
      end else if (close && t == 4 + TRP) begin
        e_cmd = 3; e_ba = rb; e_addr = row; rq = "R5";
      end else if (!close && t == cl + 2) begin
        e_cmd = 4; e_ba = wb; e_addr = wcol; rq = "R7";
      end
      e_dqm = !close && t >= cl - 1 && t <= cl + 1;
      e_oe  = !close && t == cl + 2;
      e_bv  = close ? (t >= cl && t <= cl + 3) : (t == cl);
      e_num = t - cl;
      chk(cmd_now() == e_cmd, rq, "command", cmd_now(), e_cmd);
      chk(int'(sd_ba) == e_ba, rq, "bank", int'(sd_ba), e_ba);
      chk(int'(sd_addr) == e_addr, rq, "address", int'(sd_addr), e_addr);
      chk(sd_dqm == e_dqm, "R6", "mask", int'(sd_dqm), int'(e_dqm));
      chk(wr_oe == e_oe, "R7", "write enable", int'(wr_oe), int'(e_oe));
      chk(rd_beat_valid == e_bv, close ? "R3" : "R6", "beat valid", int'(rd_beat_valid), int'(e_bv));
      if (e_bv)
        chk(int'(rd_beat_num) == e_num, close ? "R3" : "R6", "beat index", int'(rd_beat_num), e_num);
      chk(req_ready == (t == last), t == last ? "R8" : "R2", "ready", int'(req_ready), int'(t == last));
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle_outputs("R1");
    rst = 1'b0;
    @(negedge clk);
    check_idle_outputs("R1");
    for (int c = 0; c < 2; c++)
      for (int m = 0; m < 2; m++)
        for (int a = 0; a < 2; a++)
          for (int b = 0; b < 4; b++)
            run_one(bit'(c), bit'(m), bit'(a), b, 3 - b,
                    16 * b + 4 * c + a + 1, 512 + 8 * b + m, 4096 + 100 * b + 7 * c);
    @(negedge clk);
    check_idle_outputs("R9");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule